// File: doc/BRIEF.md
# Multiplexed Display RAM Write Addresser

This block sits between a serial bus front end and a 4-bit-wide segment display memory. The front end has already decoded the framing and the commands. It hands over three kinds of event: a pointer load, a device select, and a data byte strobe. The block keeps a word pointer into the display memory and a cascade position counter. It cuts each incoming byte into slices whose width follows the multiplex ratio, and it emits one masked word write per clock until the whole byte has been placed.

Several identical devices can share one data stream. Each device compares its cascade position counter against its own 3-bit strap. Only the device whose counter matches actually writes, but every device steps its pointer. When the pointer runs past the last word, it returns to zero and the cascade counter moves on by one. A byte whose slices straddle that point therefore lands partly in one device and partly in the next.

Top module: `seg_ram_writer`

## Requirements
- R1: After reset the block is idle (`busy` = 0, `ram_we` = 0, `ram_wmask` = 0), the pointer is 0 and the cascade counter is 0.
- R2: While idle, `ram_addr` shows the pointer. A pointer load with a value below the depth (40) sets the pointer to that value, a value of 40 or more sets it to 0, and nothing else changes the pointer while idle.
- R3: A device-select command loads `sel_value` into the cascade counter. Later slices are written only while that counter equals `hw_sub`.
- R4: Each accepted byte produces consecutive word cycles at consecutive addresses. The number of word cycles is set by `mode`: code 0 (static) gives 8, code 1 (1:2) gives 4, code 2 (1:3) gives 3 and code 3 (1:4) gives 2, so the pointer ends that many words further on.
- R5: Bits are taken most significant first. Each word receives the next N bits in RAM bits 0 upward, where N is 1, 2, 3 or 4 for mode codes 0 to 3. The mask marks exactly those bits, and the final word in 1:3 mode carries only two bits (mask 4'b0011).
- R6: `ram_we` is high in a word cycle only when the cascade counter equals `hw_sub`. A suppressed word still advances the pointer exactly as a written one does.
- R7: A word cycle at address 39 is followed by address 0, and the cascade counter increments, wrapping at 3 bits. This may happen inside a byte, and the remaining slices are gated by the new counter value.
- R8: `busy` is high for exactly the word cycles of a byte. Strobes and commands that arrive while busy are ignored, and a strobe in the same cycle as a command is dropped.
- R9: The mode is captured when a byte is accepted. Changing `mode` while busy does not alter that byte's slicing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Multiplex ratio code: 0 static, 1 1:2, 2 1:3, 3 1:4 |
| hw_sub | input | 3 | Cascade position strap of this device |
| ptr_load | input | 1 | Pointer load command strobe |
| ptr_value | input | 6 | Value for pointer load |
| sel_load | input | 1 | Device-select command strobe |
| sel_value | input | 3 | Value for the cascade counter |
| byte_valid | input | 1 | Display data byte strobe |
| byte_data | input | 8 | Display data byte |
| busy | output | 1 | Word cycles of a byte in progress |
| ram_we | output | 1 | Display RAM write enable |
| ram_addr | output | 6 | Word address; shows the pointer when idle |
| ram_wdata | output | 4 | Word write data |
| ram_wmask | output | 4 | Per-bit write enable |

## Verification
The assertions rely on `hw_sub` being held constant while a byte is being sliced. The cascade gating is evaluated per word, so a strap that moves mid-byte would make the gating differ from any per-byte expectation. The stimulus changes the strap only between bytes, while `busy` is low. The stimulus deliberately sends strobes, commands and mode changes during busy cycles to exercise R8 and R9. It also drives a long 1:3 run from a suppressed device into the next, so that the crossing falls inside the fourteenth byte.

// File: rtl/seg_wr_pkg.sv
package seg_wr_pkg;

   typedef enum logic [1:0] {
      MODE_STATIC = 2'd0,
      MODE_DUO    = 2'd1,
      MODE_TRI    = 2'd2,
      MODE_QUAD   = 2'd3
   } disp_mode_e;

   // number of byte bits placed into each RAM word for a given ratio
   function automatic int unsigned bits_per_word(disp_mode_e m);
      case (m)
         MODE_STATIC: return 1;
         MODE_DUO:    return 2;
         MODE_TRI:    return 3;
         default:     return 4;
      endcase
   endfunction

endpackage

// File: rtl/seg_wr_pointer.sv
module seg_wr_pointer #(
   parameter int DEPTH = 40,
   parameter int SUB_W = 3,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_ptr,
   input  logic [AW-1:0]    ptr_value,
   input  logic             load_sub,
   input  logic [SUB_W-1:0] sub_value,
   input  logic             advance,
   output logic [AW-1:0]    ptr_q,
   output logic [SUB_W-1:0] sub_q
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   if (DEPTH < 2) begin : g_depth_bad
      $error("seg_wr_pointer: DEPTH must be at least 2");
   end

   logic in_range;
   logic at_last;

   assign in_range = {1'b0, ptr_value} < (AW+1)'(DEPTH);
   assign at_last  = (ptr_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (load_ptr) begin
         ptr_q <= in_range ? ptr_value : '0;
      end else if (advance) begin
         ptr_q <= at_last ? '0 : ptr_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_q <= '0;
      end else if (load_sub) begin
         sub_q <= sub_value;
      end else if (advance && at_last) begin
         sub_q <= sub_q + 1'b1;
      end
   end

endmodule

// File: rtl/seg_wr_slicer.sv
module seg_wr_slicer
   import seg_wr_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int WORD_W = 4,
   localparam int CW    = $clog2(BYTE_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  disp_mode_e        mode,
   input  logic [BYTE_W-1:0] data,
   output logic              busy,
   output logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] wmask
);
   if (WORD_W < 4) begin : g_word_bad
      $error("seg_wr_slicer: WORD_W must hold the widest slice (4)");
   end
   if (BYTE_W < WORD_W) begin : g_byte_bad
      $error("seg_wr_slicer: BYTE_W must not be narrower than WORD_W");
   end

   logic [BYTE_W-1:0] shr_q;
   logic [CW-1:0]     left_q;
   disp_mode_e        mode_q;
   logic              busy_q;
   logic [CW-1:0]     step;
   logic [CW-1:0]     take;

   assign step = CW'(bits_per_word(mode_q));
   assign take = (left_q < step) ? left_q : step;
   assign busy = busy_q;

   // bit i of the word carries the i-th remaining byte bit, MSB first
   for (genvar i = 0; i < WORD_W; i++) begin : g_lane
      assign wmask[i] = busy_q && (CW'(i) < take);
      assign wdata[i] = wmask[i] & shr_q[BYTE_W-1-i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         shr_q  <= '0;
         left_q <= '0;
         mode_q <= MODE_STATIC;
      end else if (start) begin
         busy_q <= 1'b1;
         shr_q  <= data;
         left_q <= CW'(BYTE_W);
         mode_q <= mode;
      end else if (busy_q) begin
         if (left_q <= step) begin
            busy_q <= 1'b0;
            left_q <= '0;
         end else begin
            shr_q  <= shr_q << step;
            left_q <= left_q - step;
         end
      end
   end

endmodule

// File: rtl/seg_ram_writer.sv
module seg_ram_writer
   import seg_wr_pkg::*;
#(
   parameter int DEPTH  = 40,
   parameter int SUB_W  = 3,
   parameter int BYTE_W = 8,
   parameter int WORD_W = 4,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic [SUB_W-1:0]  hw_sub,
   input  logic              ptr_load,
   input  logic [AW-1:0]     ptr_value,
   input  logic              sel_load,
   input  logic [SUB_W-1:0]  sel_value,
   input  logic              byte_valid,
   input  logic [BYTE_W-1:0] byte_data,
   output logic              busy,
   output logic              ram_we,
   output logic [AW-1:0]     ram_addr,
   output logic [WORD_W-1:0] ram_wdata,
   output logic [WORD_W-1:0] ram_wmask
);
   logic             start;
   logic             load_ptr;
   logic             load_sub;
   logic [AW-1:0]    ptr_q;
   logic [SUB_W-1:0] sub_q;
   disp_mode_e       mode_in;

   assign mode_in  = disp_mode_e'(mode);
   assign load_ptr = ptr_load && !busy;
   assign load_sub = sel_load && !busy;
   assign start    = byte_valid && !busy && !ptr_load && !sel_load;

   seg_wr_pointer #(
      .DEPTH (DEPTH),
      .SUB_W (SUB_W)
   ) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_ptr  (load_ptr),
      .ptr_value (ptr_value),
      .load_sub  (load_sub),
      .sub_value (sel_value),
      .advance   (busy),
      .ptr_q     (ptr_q),
      .sub_q     (sub_q)
   );

   seg_wr_slicer #(
      .BYTE_W (BYTE_W),
      .WORD_W (WORD_W)
   ) u_slice (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .mode  (mode_in),
      .data  (byte_data),
      .busy  (busy),
      .wdata (ram_wdata),
      .wmask (ram_wmask)
   );

   assign ram_addr = ptr_q;
   assign ram_we   = busy && (sub_q == hw_sub);

endmodule

// File: rtl/seg_wr_chk.sv
module seg_wr_chk #(
   parameter int DEPTH  = 40,
   parameter int SUB_W  = 3,
   parameter int WORD_W = 4,
   localparam int AW    = $clog2(DEPTH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              ram_we,
   input logic [AW-1:0]     ram_addr,
   input logic [WORD_W-1:0] ram_wmask,
   input logic              ptr_load,
   input logic [SUB_W-1:0]  sub_q
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> busy); // R6

   AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, ram_addr} < (AW+1)'(DEPTH)); // R4

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (!busy || ram_addr == (($past(ram_addr) == LAST) ? '0 : $past(ram_addr) + 1'b1))); // R4

   AST_SUB_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ram_addr == LAST) |=> sub_q == SUB_W'($past(sub_q) + 1'b1)); // R7

   AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (ram_wmask[0] && ((ram_wmask & (ram_wmask + 1'b1)) == '0))); // R5

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (ram_wmask == '0 && !ram_we)); // R8

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !ptr_load) |=> $stable(ram_addr)); // R2

endmodule

bind seg_ram_writer seg_wr_chk #(
   .DEPTH  (DEPTH),
   .SUB_W  (SUB_W),
   .WORD_W (WORD_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .ram_we    (ram_we),
   .ram_addr  (ram_addr),
   .ram_wmask (ram_wmask),
   .ptr_load  (ptr_load),
   .sub_q     (sub_q)
);

// File: tb/seg_ram_writer_test.sv
`timescale 1ns/1ps
module seg_ram_writer_test;
   localparam int DEPTH = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'd0;
   logic [2:0] hw_sub = 3'd0;
   logic       ptr_load = 1'b0;
   logic [5:0] ptr_value = '0;
   logic       sel_load = 1'b0;
   logic [2:0] sel_value = '0;
   logic       byte_valid = 1'b0;
   logic [7:0] byte_data = '0;
   logic       busy, ram_we;
   logic [5:0] ram_addr;
   logic [3:0] ram_wdata, ram_wmask;

   always #2 clk = ~clk;

   seg_ram_writer uut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .hw_sub(hw_sub),
      .ptr_load(ptr_load), .ptr_value(ptr_value),
      .sel_load(sel_load), .sel_value(sel_value),
      .byte_valid(byte_valid), .byte_data(byte_data),
      .busy(busy), .ram_we(ram_we), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .ram_wmask(ram_wmask)
   );

   typedef struct {
      bit       we;
      int       addr;
      bit [3:0] data;
      bit [3:0] mask;
   } word_exp_t;

   word_exp_t  q[$];
   int         m_ptr, m_sub;
   bit [3:0]   mem_m [DEPTH];
   bit [3:0]   mem_d [DEPTH];
   int         n_chk = 0, n_fail = 0;
   bit         finished = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
      end
   endtask

   task automatic expand(input int md, input bit [7:0] d);
      int left = 8;
      int per  = md + 1;
      while (left > 0) begin
         word_exp_t w;
         int nb = (left < per) ? left : per;
         w.mask = '0;
         w.data = '0;
         for (int k = 0; k < nb; k++) begin
            w.mask[k] = 1'b1;
            w.data[k] = d[left-1-k];
         end
         w.we   = (m_sub == int'(hw_sub));
         w.addr = m_ptr;
         q.push_back(w);
         m_ptr++;
         if (m_ptr == DEPTH) begin
            m_ptr = 0;
            m_sub = (m_sub + 1) % 8;
         end
         left -= nb;
      end
   endtask

   // reference model and per-cycle comparison
   always @(posedge clk) begin
      if (rst_n && ram_we && ram_addr < DEPTH)
         mem_d[ram_addr] = (mem_d[ram_addr] & ~ram_wmask) | (ram_wdata & ram_wmask);
      if (!rst_n) begin
         q.delete();
         m_ptr = 0;
         m_sub = 0;
      end else if (q.size() > 0) begin
         if (q[0].we)
            mem_m[q[0].addr] = (mem_m[q[0].addr] & ~q[0].mask) | (q[0].data & q[0].mask);
         void'(q.pop_front());
      end else begin
         if (ptr_load) m_ptr = (ptr_value < DEPTH) ? int'(ptr_value) : 0;
         if (sel_load) m_sub = int'(sel_value);
         if (!ptr_load && !sel_load && byte_valid) expand(int'(mode), byte_data);
      end
      #1;
      chk(busy === (q.size() > 0), "R8 busy", int'(busy), int'(q.size() > 0));
      if (q.size() > 0) begin
         chk(ram_addr === q[0].addr[5:0], "R4 addr", int'(ram_addr), q[0].addr);
         chk(ram_wdata === q[0].data, "R5 data", int'(ram_wdata), int'(q[0].data));
         chk(ram_wmask === q[0].mask, "R5 R9 mask", int'(ram_wmask), int'(q[0].mask));
         chk(ram_we === q[0].we, "R3 R6 R7 we", int'(ram_we), int'(q[0].we));
      end else begin
         chk(ram_we === 1'b0 && ram_wmask === 4'h0, "R8 idle write", int'(ram_we), 0);
         chk(ram_addr === m_ptr[5:0], "R2 pointer", int'(ram_addr), m_ptr);
      end
   end

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic load_ptr(input int v);
      @(negedge clk); ptr_load = 1'b1; ptr_value = 6'(v);
      @(negedge clk); ptr_load = 1'b0;
   endtask

   task automatic load_sel(input int v);
      @(negedge clk); sel_load = 1'b1; sel_value = 3'(v);
      @(negedge clk); sel_load = 1'b0;
   endtask

   task automatic send(input int md, input bit [7:0] d);
      @(negedge clk); mode = 2'(md); byte_valid = 1'b1; byte_data = d;
      @(negedge clk); byte_valid = 1'b0;
      wait_idle();
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) begin mem_m[i] = '0; mem_d[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy === 1'b0 && ram_we === 1'b0, "R1 idle after reset", int'(busy), 0);
      chk(ram_addr === 6'd0, "R1 pointer after reset", int'(ram_addr), 0);

      load_ptr(45);
      chk(ram_addr === 6'd0, "R2 out-of-range load", int'(ram_addr), 0);
      load_ptr(12);
      chk(ram_addr === 6'd12, "R2 in-range load", int'(ram_addr), 12);

      hw_sub = 3'd3;
      load_sel(3);
      send(0, 8'hA5);
      chk(ram_addr === 6'd20, "R4 static step of 8", int'(ram_addr), 20);
      chk(mem_d[12] === 4'h1 && mem_d[13] === 4'h0, "R3 R5 static bits", int'(mem_d[12]), 1);
      send(1, 8'h9C);
      chk(ram_addr === 6'd24, "R4 1:2 step of 4", int'(ram_addr), 24);
      send(3, 8'h3E);
      chk(ram_addr === 6'd26, "R4 1:4 step of 2", int'(ram_addr), 26);
      chk(mem_d[24] === 4'hC && mem_d[25] === 4'h7, "R5 1:4 nibbles", int'(mem_d[24]), 12);

      // cascade crossing inside the fourteenth 1:3 byte
      hw_sub = 3'd1;
      load_sel(0);
      load_ptr(0);
      for (int b = 0; b < 13; b++) send(2, 8'(b * 37 + 5));
      send(2, 8'hB3);
      chk(ram_addr === 6'd2, "R7 wrap inside byte", int'(ram_addr), 2);
      chk(mem_d[0] === 4'h1, "R7 first slice after wrap", int'(mem_d[0]), 1);
      chk(mem_d[1] === 4'h3, "R5 R7 short last slice", int'(mem_d[1]), 3);
      chk(mem_d[39] === 4'h0, "R6 suppressed before wrap", int'(mem_d[39]), 0);

      // mode change, strobe and command during busy are ignored
      @(negedge clk); mode = 2'd3; byte_valid = 1'b1; byte_data = 8'h5A;
      @(negedge clk); byte_valid = 1'b1; ptr_load = 1'b1; ptr_value = 6'd30; mode = 2'd0;
      @(negedge clk); byte_valid = 1'b0; ptr_load = 1'b0;
      wait_idle();
      chk(ram_addr === 6'd4, "R8 R9 ignored while busy", int'(ram_addr), 4);
      chk(mem_d[2] === 4'hA && mem_d[3] === 4'h5, "R9 captured mode", int'(mem_d[2]), 10);

      // strobe together with a command is dropped
      @(negedge clk); byte_valid = 1'b1; sel_load = 1'b1; sel_value = 3'd1; byte_data = 8'hFF;
      @(negedge clk); byte_valid = 1'b0; sel_load = 1'b0;
      @(negedge clk);
      chk(busy === 1'b0 && ram_addr === 6'd4, "R8 strobe with command dropped", int'(busy), 0);

      // mixed traffic
      for (int n = 0; n < 80; n++) begin
         int r = int'($urandom % 16);
         if (r == 0) load_ptr(int'($urandom % 48));
         else if (r == 1) load_sel(int'($urandom % 4));
         else if (r == 2) hw_sub = 3'($urandom % 4);
         send(int'($urandom % 4), 8'($urandom));
      end
      repeat (2) @(negedge clk);
      for (int i = 0; i < DEPTH; i++)
         chk(mem_d[i] === mem_m[i], "R6 stored contents", int'(mem_d[i]), int'(mem_m[i]));
      finish_run();
   end

endmodule